// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Channel

This block is one timer channel with two free-running 16-bit time bases of its own. The first time base counts system clocks through a power-of-two prescaler. The second counts either system clocks or rising edges of an external clock pin, through a second, independent prescaler. The external pin is first brought into the clock domain by a two-flop synchronizer.

The channel has a 16-bit match register and a 16-bit capture register. Each has its own time base select, so the channel can compare against one counter while it captures from the other. The comparison is a wrap-aware greater-than-or-equal test. Writing the match register arms the comparator. The comparator then fires exactly once, as soon as the selected counter has reached or passed the stored value. This includes a value that already lies in the past.

In output mode a match drives the pin through a programmable action. In input mode, a selected transition of the synchronized pin latches the selected counter into the capture register. Each event sets its own sticky flag, and each flag has its own clear strobe.

Top module: `dtb_capcomp`

## Requirements
- R1: While reset is asserted, both time base values, the capture register, both flags and `pin_out` read zero.
- R2: Time base 1 advances by one every 2^`tb1_div` system clocks, for `tb1_div` from 0 to 7.
- R3: With `tb2_ext_sel`=0, time base 2 advances by one every 2^`tb2_div` system clocks. With `tb2_ext_sel`=1, it advances once per 2^`tb2_div` synchronized rising edges of `ext_clk`, and it holds its value while `ext_clk` is static.
- R4: A `match_wr` strobe loads `match_wdata` and arms the comparator. An armed comparator fires when (selected time base − match value) mod 2^16 is below 2^15, and it then disarms. One write therefore produces exactly one match, including for a value already passed, and no match while the value is still ahead.
- R5: `match_flag` is set by a match and stays set until a `clr_match` strobe. When both happen in the same cycle, the set wins.
- R6: `pin_oe` equals `dir_out`. On a match with `dir_out`=1, `pin_out` follows `match_action`: 00 holds, 01 drives high, 10 drives low, 11 toggles. With `dir_out`=0, a match sets the flag and leaves `pin_out` unchanged.
- R7: With `dir_out`=0, a transition of `pin_in` selected by `edge_sel` loads the selected time base into `capture_val` and sets the sticky `cap_flag`. The encoding is 00 none, 01 rising, 10 falling, 11 either. The value loaded is the counter value in the cycle the synchronized edge is seen. `clr_cap` clears the flag.
- R8: `match_tb_sel` and `cap_tb_sel` each choose independently between time base 1 (0) and time base 2 (1).
- R9: With `dir_out`=1, transitions on `pin_in` neither change `capture_val` nor set `cap_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb1_div | input | 3 | Time base 1 prescale exponent |
| tb2_div | input | 3 | Time base 2 prescale exponent |
| tb2_ext_sel | input | 1 | 1: time base 2 counts external clock edges |
| ext_clk | input | 1 | Asynchronous external clock for time base 2 |
| match_tb_sel | input | 1 | Time base for the comparator (0: TB1, 1: TB2) |
| cap_tb_sel | input | 1 | Time base for capture (0: TB1, 1: TB2) |
| dir_out | input | 1 | 1: pin is an output, 0: pin is an input |
| edge_sel | input | 2 | Capture edge select |
| match_action | input | 2 | Pin action on match |
| match_wr | input | 1 | Load strobe for the match register |
| match_wdata | input | 16 | Match value |
| clr_match | input | 1 | Clears the match flag |
| clr_cap | input | 1 | Clears the capture flag |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| tb1_value | output | 16 | Time base 1 count |
| tb2_value | output | 16 | Time base 2 count |
| capture_val | output | 16 | Capture register |
| match_flag | output | 1 | Sticky match flag |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench writes match values that lie behind, just ahead of and far ahead of the counter. A plain equality compare would miss the value in the past. A comparator that does not disarm would keep toggling the pin. A signed compare that ignores the window would fire early on the far value. The bench also freezes time base 2 by holding the external clock still, then matches and captures against it. A design that mixed up the two selects, or counted unsynchronized levels instead of edges, would show a wrong or moving value. Finally, the bench checks the capture value against the counter one cycle after the flag rises. It checks each edge encoding, and it checks that a match in input mode leaves the pin alone and that pin edges in output mode capture nothing.

// File: rtl/dtb_pkg.sv
`timescale 1ns/1ps
package dtb_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_HIGH   = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;
endpackage

// File: rtl/dtb_sync.sv
`timescale 1ns/1ps
module dtb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic q_prev
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[SH_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nxt;
    end
  end

  assign q      = sh_q[STAGES-1];
  assign q_prev = sh_q[STAGES];
endmodule

// File: rtl/dtb_timebase.sv
`timescale 1ns/1ps
module dtb_timebase #(
  parameter int TB_W  = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [DIV_W-1:0] div_sel,
  output logic [TB_W-1:0]  count
);
  localparam int PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] ps_q, ps_nxt;
  logic [PS_W-1:0] ps_mask;
  logic [TB_W-1:0] cnt_q, cnt_nxt;
  logic            tick;

  always_comb begin
    ps_mask = (PS_W'(1) << div_sel) - PS_W'(1);
    tick    = step_en && ((ps_q & ps_mask) == ps_mask);
    ps_nxt  = ps_q;
    cnt_nxt = cnt_q;
    if (step_en) begin
      ps_nxt = ps_q + PS_W'(1);
    end
    if (tick) begin
      cnt_nxt = cnt_q + TB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      ps_q  <= ps_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/dtb_match_unit.sv
`timescale 1ns/1ps
module dtb_match_unit
  import dtb_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] base,
  input  logic            dir_out,
  input  logic [1:0]      action,
  input  logic            wr,
  input  logic [TB_W-1:0] wdata,
  input  logic            clr,
  output logic            pin_out,
  output logic            flag
);
  logic [TB_W-1:0] match_q, match_nxt;
  logic            armed_q, armed_nxt;
  logic            flag_q, flag_nxt;
  logic            pin_q, pin_nxt;
  logic [TB_W-1:0] delta;
  logic            reached;
  logic            hit;
  match_act_e      act;

  always_comb begin
    act       = match_act_e'(action);
    delta     = base - match_q;
    reached   = ~delta[TB_W-1];
    hit       = armed_q && reached && !wr;

    match_nxt = match_q;
    armed_nxt = armed_q;
    if (wr) begin
      match_nxt = wdata;
      armed_nxt = 1'b1;
    end else if (hit) begin
      armed_nxt = 1'b0;
    end

    flag_nxt = flag_q;
    if (hit) begin
      flag_nxt = 1'b1;
    end else if (clr) begin
      flag_nxt = 1'b0;
    end

    pin_nxt = pin_q;
    if (hit && dir_out) begin
      case (act)
        ACT_HIGH:   pin_nxt = 1'b1;
        ACT_LOW:    pin_nxt = 1'b0;
        ACT_TOGGLE: pin_nxt = ~pin_q;
        default:    pin_nxt = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      match_q <= match_nxt;
      armed_q <= armed_nxt;
      flag_q  <= flag_nxt;
      pin_q   <= pin_nxt;
    end
  end

  assign pin_out = pin_q;
  assign flag    = flag_q;
endmodule

// File: rtl/dtb_capture_unit.sv
`timescale 1ns/1ps
module dtb_capture_unit
  import dtb_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] base,
  input  logic            dir_out,
  input  logic [1:0]      edge_sel,
  input  logic            pin_lvl,
  input  logic            pin_prev,
  input  logic            clr,
  output logic [TB_W-1:0] value,
  output logic            flag
);
  logic [TB_W-1:0] cap_q, cap_nxt;
  logic            flag_q, flag_nxt;
  logic            rise, fall, take;
  edge_sel_e       esel;

  always_comb begin
    esel = edge_sel_e'(edge_sel);
    rise = pin_lvl & ~pin_prev;
    fall = ~pin_lvl & pin_prev;
    case (esel)
      EDGE_RISE: take = rise;
      EDGE_FALL: take = fall;
      EDGE_ANY:  take = rise | fall;
      default:   take = 1'b0;
    endcase
    take = take && !dir_out;

    cap_nxt  = take ? base : cap_q;
    flag_nxt = flag_q;
    if (take) begin
      flag_nxt = 1'b1;
    end else if (clr) begin
      flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign value = cap_q;
  assign flag  = flag_q;
endmodule

// File: rtl/dtb_capcomp.sv
`timescale 1ns/1ps
module dtb_capcomp #(
  parameter int TB_W        = 16,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tb1_div,
  input  logic [DIV_W-1:0] tb2_div,
  input  logic             tb2_ext_sel,
  input  logic             ext_clk,
  input  logic             match_tb_sel,
  input  logic             cap_tb_sel,
  input  logic             dir_out,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       match_action,
  input  logic             match_wr,
  input  logic [TB_W-1:0]  match_wdata,
  input  logic             clr_match,
  input  logic             clr_cap,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [TB_W-1:0]  tb1_value,
  output logic [TB_W-1:0]  tb2_value,
  output logic [TB_W-1:0]  capture_val,
  output logic             match_flag,
  output logic             cap_flag
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sh;
  logic                  rst_i_n;
  logic                  ext_lvl, ext_prev, ext_rise;
  logic                  pin_lvl, pin_prev;
  logic                  tb2_step;
  logic [TB_W-1:0]       tb1_q, tb2_q;
  logic [TB_W-1:0]       match_base, cap_base;

  // reset: asserted at once, released after RST_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh <= '0;
    end else begin
      rst_sh <= {rst_sh[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_i_n = rst_sh[RST_STAGES-1];

  dtb_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_i_n), .din(ext_clk), .q(ext_lvl), .q_prev(ext_prev)
  );

  dtb_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_i_n), .din(pin_in), .q(pin_lvl), .q_prev(pin_prev)
  );

  always_comb begin
    ext_rise   = ext_lvl & ~ext_prev;
    tb2_step   = tb2_ext_sel ? ext_rise : 1'b1;
    match_base = match_tb_sel ? tb2_q : tb1_q;
    cap_base   = cap_tb_sel ? tb2_q : tb1_q;
  end

  dtb_timebase #(.TB_W(TB_W), .DIV_W(DIV_W)) u_tb1 (
    .clk(clk), .rst_n(rst_i_n), .step_en(1'b1), .div_sel(tb1_div), .count(tb1_q)
  );

  dtb_timebase #(.TB_W(TB_W), .DIV_W(DIV_W)) u_tb2 (
    .clk(clk), .rst_n(rst_i_n), .step_en(tb2_step), .div_sel(tb2_div), .count(tb2_q)
  );

  dtb_match_unit #(.TB_W(TB_W)) u_match (
    .clk(clk), .rst_n(rst_i_n), .base(match_base), .dir_out(dir_out),
    .action(match_action), .wr(match_wr), .wdata(match_wdata), .clr(clr_match),
    .pin_out(pin_out), .flag(match_flag)
  );

  dtb_capture_unit #(.TB_W(TB_W)) u_capture (
    .clk(clk), .rst_n(rst_i_n), .base(cap_base), .dir_out(dir_out),
    .edge_sel(edge_sel), .pin_lvl(pin_lvl), .pin_prev(pin_prev), .clr(clr_cap),
    .value(capture_val), .flag(cap_flag)
  );

  assign pin_oe    = dir_out;
  assign tb1_value = tb1_q;
  assign tb2_value = tb2_q;
endmodule

// File: rtl/dtb_capcomp_checker.sv
`timescale 1ns/1ps
module dtb_capcomp_checker #(
  parameter int TB_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dir_out,
  input logic            clr_match,
  input logic            clr_cap,
  input logic            pin_out,
  input logic [TB_W-1:0] tb1_value,
  input logic [TB_W-1:0] capture_val,
  input logic            match_flag,
  input logic            cap_flag
);
  // R2: time base 1 never jumps by more than one count per clock
  a_r2_tb1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tb1_value == $past(tb1_value) || tb1_value == $past(tb1_value) + TB_W'(1)));

  // R5: match flag stays set until cleared
  a_r5_match_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_match) |=> match_flag);

  // R7: capture flag stays set until cleared
  a_r7_cap_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !clr_cap) |=> cap_flag);

  // R6: in input mode the pin level is never altered
  a_r6_pin_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |=> $stable(pin_out));

  // R9: in output mode the capture register is never reloaded
  a_r9_capture_frozen_output: assert property (@(posedge clk) disable iff (!rst_n)
    dir_out |=> $stable(capture_val));
endmodule

bind dtb_capcomp dtb_capcomp_checker #(.TB_W(TB_W)) u_dtb_capcomp_checker (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .clr_match(clr_match),
  .clr_cap(clr_cap), .pin_out(pin_out), .tb1_value(tb1_value),
  .capture_val(capture_val), .match_flag(match_flag), .cap_flag(cap_flag)
);

// File: tb/dtb_capcomp_bench.sv
`timescale 1ns/1ps
module dtb_capcomp_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  tb1_div, tb2_div;
  logic        tb2_ext_sel, ext_clk, match_tb_sel, cap_tb_sel, dir_out;
  logic [1:0]  edge_sel, match_action;
  logic        match_wr, clr_match, clr_cap, pin_in;
  logic [15:0] match_wdata;
  logic        pin_out, pin_oe, match_flag, cap_flag;
  logic [15:0] tb1_value, tb2_value, capture_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dtb_capcomp u_dtb_capcomp (
    .clk(clk), .rst_n(rst_n), .tb1_div(tb1_div), .tb2_div(tb2_div),
    .tb2_ext_sel(tb2_ext_sel), .ext_clk(ext_clk), .match_tb_sel(match_tb_sel),
    .cap_tb_sel(cap_tb_sel), .dir_out(dir_out), .edge_sel(edge_sel),
    .match_action(match_action), .match_wr(match_wr), .match_wdata(match_wdata),
    .clr_match(clr_match), .clr_cap(clr_cap), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tb1_value(tb1_value),
    .tb2_value(tb2_value), .capture_val(capture_val),
    .match_flag(match_flag), .cap_flag(cap_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_match(input logic [15:0] v);
    match_wdata = v; match_wr = 1'b1; tick(1); match_wr = 1'b0;
  endtask

  task automatic clear_match();
    clr_match = 1'b1; tick(1); clr_match = 1'b0;
  endtask

  task automatic clear_cap();
    clr_cap = 1'b1; tick(1); clr_cap = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; tick(3); ext_clk = 1'b0; tick(3);
    end
    tick(5);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(4);
    chk("R1", "tb1", tb1_value, 0);
    chk("R1", "tb2", tb2_value, 0);
    chk("R1", "capture", capture_val, 0);
    chk("R1", "match_flag", match_flag, 0);
    chk("R1", "cap_flag", cap_flag, 0);
    chk("R1", "pin_out", pin_out, 0);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic t_prescale();
    logic [15:0] a;
    int k[3] = '{0, 3, 7};
    for (int i = 0; i < 3; i++) begin
      tb1_div = 3'(k[i]);
      tick(130);
      a = tb1_value;
      tick(256);
      chk("R2", "tb1 advance", 32'(tb1_value - a), 32'(256 >> k[i]));
    end
    tb1_div = 3'd0;
    tb2_ext_sel = 1'b0; tb2_div = 3'd2;
    tick(130);
    a = tb2_value;
    tick(256);
    chk("R3", "tb2 internal advance", 32'(tb2_value - a), 64);
  endtask

  task automatic t_ext_clock();
    logic [15:0] a;
    tb2_ext_sel = 1'b1; tb2_div = 3'd0;
    tick(10);
    a = tb2_value;
    ext_pulses(6);
    chk("R3", "tb2 ext div1", 32'(tb2_value - a), 6);
    a = tb2_value;
    tick(60);
    chk("R3", "tb2 frozen static ext", tb2_value, a);
    tb2_div = 3'd1;
    ext_pulses(6);
    chk("R3", "tb2 ext div2", 32'(tb2_value - a), 3);
    tb2_div = 3'd0;
  endtask

  task automatic t_match_future();
    dir_out = 1'b1; match_tb_sel = 1'b0; match_action = 2'b01;
    chk("R6", "pin_oe output", pin_oe, 1);
    wr_match(tb1_value + 16'd40);
    tick(30);
    chk("R4", "flag before reach", match_flag, 0);
    chk("R6", "pin before reach", pin_out, 0);
    tick(15);
    chk("R4", "flag after reach", match_flag, 1);
    chk("R6", "set high action", pin_out, 1);
    tick(100);
    chk("R5", "flag sticky", match_flag, 1);
    clear_match();
    chk("R5", "flag cleared", match_flag, 0);
  endtask

  task automatic t_match_past_once();
    match_action = 2'b11;
    wr_match(tb1_value - 16'd100);
    tick(3);
    chk("R4", "past value fires", match_flag, 1);
    chk("R6", "toggle action", pin_out, 0);
    clear_match();
    tick(50);
    chk("R4", "no refire flag", match_flag, 0);
    chk("R4", "no refire pin", pin_out, 0);
  endtask

  task automatic t_match_actions();
    match_action = 2'b00;
    wr_match(tb1_value - 16'd5);
    tick(3);
    chk("R6", "hold action flag", match_flag, 1);
    chk("R6", "hold action pin", pin_out, 0);
    clear_match();
    match_action = 2'b01;
    wr_match(tb1_value - 16'd5);
    tick(3);
    chk("R6", "high action pin", pin_out, 1);
    clear_match();
    match_action = 2'b10;
    wr_match(tb1_value - 16'd5);
    tick(3);
    chk("R6", "low action pin", pin_out, 0);
    clear_match();
    match_action = 2'b01;
    wr_match(tb1_value + 16'd1000);
    tick(200);
    chk("R4", "far future no fire", match_flag, 0);
    chk("R4", "far future pin", pin_out, 0);
  endtask

  task automatic t_match_tb2();
    tb2_ext_sel = 1'b1; match_tb_sel = 1'b1; match_action = 2'b11;
    tick(5);
    wr_match(tb2_value + 16'd3);
    tick(50);
    chk("R8", "tb2 match held while frozen", match_flag, 0);
    ext_pulses(3);
    chk("R8", "tb2 match after 3 edges", match_flag, 1);
    chk("R8", "tb2 match pin", pin_out, 1);
    clear_match();
  endtask

  task automatic t_input_mode_match();
    dir_out = 1'b0; match_tb_sel = 1'b0; match_action = 2'b11;
    chk("R6", "pin_oe input", pin_oe, 0);
    wr_match(tb1_value - 16'd7);
    tick(3);
    chk("R6", "input mode flag", match_flag, 1);
    chk("R6", "input mode pin kept", pin_out, 1);
    clear_match();
  endtask

  task automatic t_capture();
    logic [15:0] n;
    logic [15:0] held;
    dir_out = 1'b0; cap_tb_sel = 1'b1; edge_sel = 2'b01; pin_in = 1'b0;
    tick(6);
    n = tb2_value;
    pin_in = 1'b1; tick(6);
    chk("R7", "rise capture flag", cap_flag, 1);
    chk("R8", "capture from tb2", capture_val, n);
    clear_cap();
    pin_in = 1'b0; tick(6);
    chk("R7", "falling ignored in rise mode", cap_flag, 0);
    edge_sel = 2'b11;
    pin_in = 1'b1; tick(6);
    chk("R7", "either edge flag", cap_flag, 1);
    clear_cap();
    cap_tb_sel = 1'b0; edge_sel = 2'b10;
    pin_in = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (cap_flag) break;
    end
    chk("R7", "fall capture flag", cap_flag, 1);
    chk("R7", "capture tb1 value", capture_val, tb1_value - 16'd1);
    clear_cap();
    edge_sel = 2'b00;
    held = capture_val;
    pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
    chk("R7", "none mode flag", cap_flag, 0);
    chk("R7", "none mode value", capture_val, held);
    dir_out = 1'b1; edge_sel = 2'b11;
    pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
    chk("R9", "output mode no flag", cap_flag, 0);
    chk("R9", "output mode value", capture_val, held);
  endtask

  initial begin
    rst_n = 1'b0; tb1_div = 3'd0; tb2_div = 3'd0; tb2_ext_sel = 1'b0;
    ext_clk = 1'b0; match_tb_sel = 1'b0; cap_tb_sel = 1'b0; dir_out = 1'b0;
    edge_sel = 2'b00; match_action = 2'b00; match_wr = 1'b0;
    match_wdata = 16'd0; clr_match = 1'b0; clr_cap = 1'b0; pin_in = 1'b0;
    t_reset();
    t_prescale();
    t_ext_clock();
    t_match_future();
    t_match_past_once();
    t_match_actions();
    t_match_tb2();
    t_input_mode_match();
    t_capture();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule